// File: doc/BRIEF.md
# Seconds Prescaler with Round-to-Minute Adjust

This block takes a reference tick and divides it through a binary chain of sub-second stages. Each time the whole chain rolls over, it produces a one-second carry. That carry advances a seconds counter that runs 0 to 59. When the seconds counter wraps, the block asks the minute counter for a single step. Two taps of the chain give one-cycle 16 Hz and 1 Hz pulses, and each pulse has its own active-low enable.

Counting above the divider can be frozen with a run-enable level. The sub-second chain keeps running during the freeze. If the chain rolls over while counting is frozen, that second is kept in a single-bit hold register and credited as soon as counting resumes. A pause shorter than one second therefore leaves the time unchanged.

An adjust strobe rounds the seconds to the nearest minute. It clears the chain and the seconds. If the seconds were at 30 or more, it also asks for a minute step. A separate clear strobe restarts the sub-second chain from zero.

Top module: `sec_prescaler`

## Requirements
- R1: After a synchronous reset, `sec_val` is 0 and `min_step`, `pulse16` and `pulse1` are all 0.
- R2: The chain counts one step per cycle with `ref_tick` high and wraps after 2^DIV_W steps. On the wrap, with `run_en` high, `sec_val` goes up by one in the next cycle. From 59 it goes to 0 and `min_step` is high for that one cycle.
- R3: An `adj_stb` cycle with `sec_val` from 0 to 29 sets `sec_val` to 0 in the next cycle, keeps `min_step` low and clears the chain.
- R4: An `adj_stb` cycle with `sec_val` from 30 to 59 sets `sec_val` to 0 and raises `min_step` for one cycle in the next cycle, and clears the chain.
- R5: While `run_en` is 0, `sec_val` does not change except through adjust. The chain keeps counting during that time.
- R6: A wrap that happens while `run_en` is 0 is held, and at most one is held. The held second is applied in the first cycle with `run_en` high, so `sec_val` rises one cycle later. If a new wrap arrives in that same cycle, it stays held for the next cycle.
- R7: A `div_clr_stb` cycle sets the chain to zero and drops any held second.
- R8: `pulse16` is high for one cycle after each tick that completes a 1/16-second stage, counted from a cleared chain, provided `tick16_off` is 0. It stays low while `tick16_off` is 1.
- R9: `pulse1` is high for one cycle after each wrap, provided `tick1_off` is 0, whatever `run_en` is. It stays low while `tick1_off` is 1.
- R10: A wrap that would occur in an `adj_stb` cycle is discarded. The adjust result alone decides `sec_val` and `min_step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference tick enable, one chain step per high cycle |
| run_en | input | 1 | Run enable for the seconds counter and above |
| adj_stb | input | 1 | One-cycle round-to-minute adjust command |
| div_clr_stb | input | 1 | One-cycle clear of the sub-second chain |
| tick16_off | input | 1 | 0 enables `pulse16` |
| tick1_off | input | 1 | 0 enables `pulse1` |
| sec_val | output | 6 | Seconds value, binary 0 to 59 |
| min_step | output | 1 | One-cycle request to increment the minutes |
| pulse16 | output | 1 | 16 Hz one-cycle pulse |
| pulse1 | output | 1 | 1 Hz one-cycle pulse |

## Verification
The bench builds the block with DIV_W = 5, so one second lasts 32 ticks and a 1/16-second stage lasts 2 ticks. With ticks on every cycle, a full minute and its wrap take about two thousand cycles. Adjusts on both sides of 30 and pauses that span one carry or many carries then fit easily. The short chain also makes it cheap to line up an adjust, a clear or a resume on the exact cycle of a wrap, and it keeps a randomly gapped tick run short.

// File: rtl/sec_prescale_pkg.sv
package sec_prescale_pkg;

    localparam int SEC_LAST      = 59;
    localparam int SEC_HALF      = 30;
    localparam int FAST_STAGES   = 4;   // 2**4 = 16 fast pulses per second

    typedef logic [5:0] sec_t;

    typedef struct packed {
        logic adjust;
        logic clear;
    } ctl_t;

    typedef struct packed {
        logic carry;
        logic tick16;
    } div_evt_t;

    typedef enum logic [1:0] {
        SEC_HOLD,
        SEC_STEP,
        SEC_WRAP,
        SEC_ROUND
    } sec_op_e;

    function automatic logic rounds_up(sec_t s);
        return s >= sec_t'(SEC_HALF);
    endfunction

    function automatic sec_op_e pick_op(logic adjust, logic advance, sec_t s);
        if (adjust)
            return SEC_ROUND;
        else if (!advance)
            return SEC_HOLD;
        else if (s == sec_t'(SEC_LAST))
            return SEC_WRAP;
        else
            return SEC_STEP;
    endfunction

endpackage

// File: rtl/sp_divider.sv
module sp_divider
    import sec_prescale_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ref_tick,
    input  ctl_t     ctl,
    output div_evt_t evt
);
    localparam int LOW_W = DIV_W - FAST_STAGES;

    logic [DIV_W-1:0] cnt;
    logic             fast_roll;
    logic             live;

    assign live = ref_tick & ~ctl.adjust & ~ctl.clear;

    generate
        if (LOW_W > 0) begin : g_fast_tap
            assign fast_roll = &cnt[LOW_W-1:0];
        end else begin : g_fast_every
            assign fast_roll = 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || ctl.adjust || ctl.clear)
            cnt <= '0;
        else if (ref_tick)
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        evt.carry  = live & (&cnt);
        evt.tick16 = live & fast_roll;
    end

endmodule

// File: rtl/sp_carry_hold.sv
module sp_carry_hold
    import sec_prescale_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic carry_in,
    input  logic run_en,
    input  ctl_t ctl,
    output logic advance
);
    logic held;
    logic kill;

    assign kill    = ctl.adjust | ctl.clear;
    assign advance = run_en & (held | carry_in) & ~kill;

    always_ff @(posedge clk) begin
        if (rst || kill)
            held <= 1'b0;
        else if (run_en)
            held <= held & carry_in;   // second carry waits one cycle
        else
            held <= held | carry_in;   // saturates at one second
    end

endmodule

// File: rtl/sp_seconds.sv
module sp_seconds
    import sec_prescale_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic advance,
    input  logic adjust,
    output sec_t sec_val,
    output logic min_step
);
    sec_op_e op;

    assign op = pick_op(adjust, advance, sec_val);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_val  <= '0;
            min_step <= 1'b0;
        end else begin
            unique case (op)
                SEC_ROUND: begin
                    min_step <= rounds_up(sec_val);
                    sec_val  <= '0;
                end
                SEC_WRAP: begin
                    min_step <= 1'b1;
                    sec_val  <= '0;
                end
                SEC_STEP: begin
                    min_step <= 1'b0;
                    sec_val  <= sec_val + 1'b1;
                end
                default: begin
                    min_step <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sp_pulse_out.sv
module sp_pulse_out
    import sec_prescale_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_evt_t evt,
    input  logic     tick16_off,
    input  logic     tick1_off,
    output logic     pulse16,
    output logic     pulse1
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse16 <= 1'b0;
            pulse1  <= 1'b0;
        end else begin
            pulse16 <= evt.tick16 & ~tick16_off;
            pulse1  <= evt.carry  & ~tick1_off;
        end
    end

endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
    import sec_prescale_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_tick,
    input  logic       run_en,
    input  logic       adj_stb,
    input  logic       div_clr_stb,
    input  logic       tick16_off,
    input  logic       tick1_off,
    output logic [5:0] sec_val,
    output logic       min_step,
    output logic       pulse16,
    output logic       pulse1
);
    ctl_t     ctl;
    div_evt_t evt;
    logic     advance;

    assign ctl.adjust = adj_stb;
    assign ctl.clear  = div_clr_stb;

    sp_divider #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .ctl      (ctl),
        .evt      (evt)
    );

    sp_carry_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .carry_in (evt.carry),
        .run_en   (run_en),
        .ctl      (ctl),
        .advance  (advance)
    );

    sp_seconds u_sec (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .adjust   (adj_stb),
        .sec_val  (sec_val),
        .min_step (min_step)
    );

    sp_pulse_out u_pulse (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .tick16_off (tick16_off),
        .tick1_off  (tick1_off),
        .pulse16    (pulse16),
        .pulse1     (pulse1)
    );

endmodule

// File: rtl/sec_prescaler_chk.sv
module sec_prescaler_chk (
    input logic       clk,
    input logic       rst,
    input logic       run_en,
    input logic       adj_stb,
    input logic       tick16_off,
    input logic       tick1_off,
    input logic [5:0] sec_val,
    input logic       min_step,
    input logic       pulse16,
    input logic       pulse1
);
    a_r3_adjust_low: assert property (@(posedge clk) disable iff (rst)
        (adj_stb && sec_val < 6'd30) |=> (sec_val == 6'd0 && !min_step));

    a_r4_adjust_high: assert property (@(posedge clk) disable iff (rst)
        (adj_stb && sec_val >= 6'd30) |=> (sec_val == 6'd0 && min_step));

    a_r5_frozen_hold: assert property (@(posedge clk) disable iff (rst)
        (!run_en && !adj_stb) |=> $stable(sec_val));

    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(sec_val) || sec_val == $past(sec_val) + 6'd1 || sec_val == 6'd0));

    a_r2_minute_at_zero: assert property (@(posedge clk) disable iff (rst)
        min_step |-> sec_val == 6'd0);

    a_r2_range: assert property (@(posedge clk) disable iff (rst)
        sec_val <= 6'd59);

    a_r8_fast_gated: assert property (@(posedge clk) disable iff (rst)
        tick16_off |=> !pulse16);

    a_r9_slow_gated: assert property (@(posedge clk) disable iff (rst)
        tick1_off |=> !pulse1);

endmodule

bind sec_prescaler sec_prescaler_chk u_chk (.*);

// File: tb/sec_prescaler_bench.sv
`timescale 1ns/1ps
module sec_prescaler_bench;
    localparam int DIV_W = 5;
    localparam int DIV_N = 1 << DIV_W;
    localparam int FAST  = DIV_N / 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_tick = 1'b0, run_en = 1'b0, adj_stb = 1'b0, div_clr_stb = 1'b0;
    logic       tick16_off = 1'b0, tick1_off = 1'b0;
    logic [5:0] sec_val;
    logic       min_step, pulse16, pulse1;

    int    n_cmp = 0, n_bad = 0;
    string phase = "R1";
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;

    // behavioural model state
    int m_div = 0, m_sec = 0;
    bit m_pend = 0;
    int e_sec = 0;
    bit e_min = 0, e_p16 = 0, e_p1 = 0;

    always #2.5 clk = ~clk;

    sec_prescaler #(.DIV_W(DIV_W)) u_sec_prescaler (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .run_en(run_en),
        .adj_stb(adj_stb), .div_clr_stb(div_clr_stb),
        .tick16_off(tick16_off), .tick1_off(tick1_off),
        .sec_val(sec_val), .min_step(min_step), .pulse16(pulse16), .pulse1(pulse1)
    );

    task automatic check(string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", phase, what, got, exp);
        end
    endtask

    // reference model, advanced on every clock edge
    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_sec = 0; m_pend = 0;
            e_min = 0; e_p16 = 0; e_p1 = 0;
        end else begin
            bit quiet, wrap, fast, go;
            quiet = !adj_stb && !div_clr_stb;
            wrap  = ref_tick && quiet && (m_div == DIV_N - 1);
            fast  = ref_tick && quiet && ((m_div % FAST) == FAST - 1);
            e_p16 = fast && !tick16_off;
            e_p1  = wrap && !tick1_off;
            go    = run_en && quiet && (m_pend || wrap);
            e_min = 0;
            if (adj_stb) begin
                e_min = (m_sec >= 30);
                m_sec = 0;
            end else if (go) begin
                if (m_sec == 59) begin m_sec = 0; e_min = 1; end
                else m_sec = m_sec + 1;
            end
            if (!quiet)      m_pend = 0;
            else if (run_en) m_pend = m_pend && wrap;
            else             m_pend = m_pend || wrap;
            if (!quiet)        m_div = 0;
            else if (ref_tick) m_div = (m_div + 1) % DIV_N;
        end
        e_sec = m_sec;
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check("sec_val (R2/R5/R6)", int'(sec_val), e_sec);
            check("min_step (R2/R3/R4)", int'(min_step), int'(e_min));
            check("pulse16 (R8)", int'(pulse16), int'(e_p16));
            check("pulse1 (R9)", int'(pulse1), int'(e_p1));
        end
    end

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic run_to_sec(int s);
        while (m_sec != s) step();
    endtask

    task automatic run_to_div(int d);
        while (m_div != d) step();
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        // R1: reset state, checked directly
        check("R1 sec_val after reset", int'(sec_val), 0);
        check("R1 min_step after reset", int'(min_step), 0);
        check("R1 pulse16 after reset", int'(pulse16), 0);
        check("R1 pulse1 after reset", int'(pulse1), 0);
        cmp_on = 1'b1;

        // R2: free run through a full minute and its wrap
        phase = "R2"; ref_tick = 1'b1; run_en = 1'b1;
        step(2100);

        // R8: fast pulse enable toggling
        phase = "R8";
        for (int i = 0; i < 20; i++) begin
            tick16_off = i[0];
            step(7);
        end
        tick16_off = 1'b0;

        // R9: slow pulse enable toggling, also while frozen
        phase = "R9";
        for (int i = 0; i < 8; i++) begin
            tick1_off = i[1];
            run_en    = !i[0];
            step(45);
        end
        tick1_off = 1'b0; run_en = 1'b1;

        // R4: adjust with seconds in the upper half
        phase = "R4";
        run_to_sec(40); adj_stb = 1'b1; step(); adj_stb = 1'b0; step(40);
        run_to_sec(30); adj_stb = 1'b1; step(); adj_stb = 1'b0; step(5);

        // R3: adjust with seconds in the lower half
        phase = "R3";
        run_to_sec(10); adj_stb = 1'b1; step(); adj_stb = 1'b0; step(40);
        run_to_sec(29); adj_stb = 1'b1; step(); adj_stb = 1'b0; step(5);

        // R10: adjust on the very cycle of a wrap
        phase = "R10";
        run_to_sec(35); run_to_div(DIV_N - 1);
        adj_stb = 1'b1; step(); adj_stb = 1'b0; step(40);
        run_to_sec(5); run_to_div(DIV_N - 1);
        adj_stb = 1'b1; step(); adj_stb = 1'b0; step(40);

        // R5: long freeze across several wraps, held second saturates
        phase = "R5";
        run_en = 1'b0; step(150); run_en = 1'b1; step(40);

        // R6: short pause spanning one wrap; resume on a wrap cycle
        phase = "R6";
        run_to_div(20); run_en = 1'b0; step(20); run_en = 1'b1; step(40);
        run_to_div(10); run_en = 1'b0; run_to_div(DIV_N - 1); run_en = 1'b1; step(40);

        // R7: clear drops the held second and restarts the chain
        phase = "R7";
        run_en = 1'b0; while (!m_pend) step(); step(3);
        div_clr_stb = 1'b1; step(); div_clr_stb = 1'b0; step(5);
        run_en = 1'b1; step(70);
        run_to_div(17); div_clr_stb = 1'b1; step(); div_clr_stb = 1'b0; step(40);

        // R2: gapped ticks with random controls
        phase = "R2";
        for (int i = 0; i < 3000; i++) begin
            ref_tick    = ($urandom_range(0, 3) != 0);
            run_en      = ($urandom_range(0, 9) != 0);
            adj_stb     = ($urandom_range(0, 299) == 0);
            div_clr_stb = ($urandom_range(0, 399) == 0);
            tick16_off  = ($urandom_range(0, 19) == 0);
            tick1_off   = ($urandom_range(0, 19) == 0);
            step();
        end
        adj_stb = 1'b0; div_clr_stb = 1'b0;
        step(5);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog %s: got hung expected completion", phase);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule